// File: doc/BRIEF.md
# Frame-Synchronous Byte Randomizer

This block scrambles the protected part of every upstream frame before that part goes to a (65,57) Reed-Solomon encoder. A frame starts with two sync bytes. Four header bytes and 53 cell bytes follow. The sync bytes leave the block unchanged. The next 57 bytes are XORed with a pseudo-random keystream. A 15-bit linear feedback shift register produces that keystream, and the register is set to all ones at the start of every frame. Any byte that arrives after those 57 bytes, or before the first start-of-frame marker after reset, also passes through unchanged.

Bytes enter with a valid strobe and a start-of-frame marker. The output is the same stream delayed by a fixed number of register stages, with the valid strobe and the marker kept aligned to the data. When valid is low, neither the byte position nor the generator moves. XORing twice with the same keystream gives back the original data, so the same circuit also serves as the derandomizer on the receive side.

Top module: `frame_scrambler`

## Requirements
- R1: With the default single output stage, `out_valid` and `out_sof` equal `in_valid` and `in_valid && in_sof` from exactly one clock earlier. `out_data` carries the processed byte whenever `out_valid` is high.
- R2: The byte that carries the start-of-frame marker, and the byte that follows it, appear on `out_data` unchanged.
- R3: Byte indices 2 to 58 of a frame are XORed with eight keystream bits. The byte carrying the marker is index 0. For each keystream bit the generator computes feedback = s[14] XOR s[13], emits that feedback bit, and shifts to {s[13:0], feedback}. The first bit emitted for a byte lands in bit 7 and the last in bit 0.
- R4: The generator reloads all ones at every start-of-frame marker. As a result, the keystream bytes for frame indices 2 and 3 are always 0x00 and 0x02.
- R5: A cycle with `in_valid` low produces `out_valid` low one cycle later. It moves neither the byte position nor the generator, so a frame sent with gaps produces the same output bytes as the same frame sent without gaps.
- R6: A start-of-frame marker that arrives before the current frame ends restarts the frame at once. Its byte becomes index 0, and the generator restarts from all ones.
- R7: Bytes from index 59 onward pass through unchanged until the next marker. So do all bytes that arrive after reset and before the first marker.
- R8: While reset is asserted, `out_valid`, `out_sof` and `out_data` are all zero.
- R9: Passing the output bytes of a frame through the block a second time, as a new frame, gives back the original bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input byte strobe |
| in_sof | input | 1 | First byte of a frame; only meaningful when in_valid is high |
| in_data | input | BYTE_W | Input byte |
| out_valid | output | 1 | Output byte strobe |
| out_sof | output | 1 | First byte of a frame on the output |
| out_data | output | BYTE_W | Scrambled or passed-through byte |

## Verification
The assertions treat `in_sof` as having meaning only when it comes with `in_valid`. They expect the generator to reload at a qualified marker and to hold its state on idle cycles. They also expect the byte carrying the marker to be a sync byte, which the default sync length of two guarantees. The stimulus drives every input on the falling clock edge and gives each frame a single marker on its first byte. It tries gaps of different lengths and also sends deliberately short frames and frames with extra trailing bytes, so that every segment transition is reached while staying within these assumptions.

// File: rtl/scr_pkg.sv
package scr_pkg;

   // Which part of the frame the current byte belongs to
   typedef enum logic [1:0] {
      SEG_SYNC     = 2'd0,
      SEG_SCRAMBLE = 2'd1,
      SEG_TAIL     = 2'd2
   } seg_e;

endpackage

// File: rtl/scr_frame_ctrl.sv
module scr_frame_ctrl
   import scr_pkg::*;
#(
   parameter int SYNC_LEN  = 2,
   parameter int SCRAM_LEN = 57
) (
   input  logic clk,
   input  logic rst_n,
   input  logic in_valid,
   input  logic in_sof,
   output seg_e seg
);
   localparam int SPAN  = SYNC_LEN + SCRAM_LEN;
   localparam int CNT_W = $clog2(SPAN + 1);
   localparam logic [CNT_W-1:0] SPAN_C = CNT_W'(SPAN);
   localparam logic [CNT_W-1:0] SYNC_C = CNT_W'(SYNC_LEN);

   logic [CNT_W-1:0] pos_q;    // index of the next byte, saturates at SPAN
   logic [CNT_W-1:0] cur_idx;

   always_comb begin
      cur_idx = (in_valid && in_sof) ? '0 : pos_q;
      if (cur_idx < SYNC_C)
         seg = SEG_SYNC;
      else if (cur_idx < SPAN_C)
         seg = SEG_SCRAMBLE;
      else
         seg = SEG_TAIL;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         pos_q <= SPAN_C;
      else if (in_valid)
         pos_q <= (cur_idx == SPAN_C) ? cur_idx : cur_idx + 1'b1;
   end

endmodule

// File: rtl/scr_lfsr.sv
module scr_lfsr #(
   parameter int LFSR_W = 15,
   parameter int TAP_HI = 15,
   parameter int TAP_LO = 14,
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              advance,
   output logic [BYTE_W-1:0] key,
   output logic [LFSR_W-1:0] state
);
   logic [LFSR_W-1:0] base;
   logic [LFSR_W-1:0] stepped;

   always_comb begin
      logic [LFSR_W-1:0] s;
      logic              fb;
      base = load ? {LFSR_W{1'b1}} : state;
      s    = base;
      key  = '0;
      for (int i = 0; i < BYTE_W; i++) begin
         fb                = s[TAP_HI-1] ^ s[TAP_LO-1];
         key[BYTE_W-1-i]   = fb;
         s                 = {s[LFSR_W-2:0], fb};
      end
      stepped = s;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         state <= {LFSR_W{1'b1}};
      else if (load || advance)
         state <= advance ? stepped : base;
   end

endmodule

// File: rtl/scr_out_pipe.sv
module scr_out_pipe #(
   parameter int W      = 10,
   parameter int STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) q <= '0;
            else        q <= d;
         end
      end else begin : g_chain
         logic [W-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < STAGES; i++) stg[i] <= '0;
            end else begin
               stg[0] <= d;
               for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/frame_scrambler.sv
module frame_scrambler
   import scr_pkg::*;
#(
   parameter int BYTE_W     = 8,
   parameter int LFSR_W     = 15,
   parameter int TAP_HI     = 15,
   parameter int TAP_LO     = 14,
   parameter int SYNC_LEN   = 2,
   parameter int SCRAM_LEN  = 57,
   parameter int OUT_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic              in_sof,
   input  logic [BYTE_W-1:0] in_data,
   output logic              out_valid,
   output logic              out_sof,
   output logic [BYTE_W-1:0] out_data
);
   localparam int PIPE_W = BYTE_W + 2;

   generate
      if (LFSR_W < 2)                          begin : g_bad_w   $error("LFSR_W too small"); end
      if (TAP_HI > LFSR_W || TAP_LO >= TAP_HI || TAP_LO < 1)
                                               begin : g_bad_tap $error("bad tap positions"); end
      if (SCRAM_LEN < 1 || SYNC_LEN < 0)       begin : g_bad_len $error("bad frame lengths"); end
      if (OUT_STAGES < 1)                      begin : g_bad_stg $error("OUT_STAGES must be >= 1"); end
      if (BYTE_W < 1)                          begin : g_bad_bw  $error("BYTE_W must be >= 1"); end
   endgenerate

   seg_e              seg;
   logic              key_load;
   logic              key_adv;
   logic [BYTE_W-1:0] key;
   logic [LFSR_W-1:0] lfsr_state;
   logic [BYTE_W-1:0] mixed;

   scr_frame_ctrl #(
      .SYNC_LEN (SYNC_LEN),
      .SCRAM_LEN(SCRAM_LEN)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .in_valid(in_valid),
      .in_sof  (in_sof),
      .seg     (seg)
   );

   assign key_load = in_valid && in_sof;
   assign key_adv  = in_valid && (seg == SEG_SCRAMBLE);

   scr_lfsr #(
      .LFSR_W(LFSR_W),
      .TAP_HI(TAP_HI),
      .TAP_LO(TAP_LO),
      .BYTE_W(BYTE_W)
   ) u_lfsr (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (key_load),
      .advance(key_adv),
      .key    (key),
      .state  (lfsr_state)
   );

   assign mixed = (seg == SEG_SCRAMBLE) ? (in_data ^ key) : in_data;

   scr_out_pipe #(
      .W     (PIPE_W),
      .STAGES(OUT_STAGES)
   ) u_pipe (
      .clk  (clk),
      .rst_n(rst_n),
      .d    ({in_valid, in_valid && in_sof, mixed}),
      .q    ({out_valid, out_sof, out_data})
   );

endmodule

// File: rtl/frame_scrambler_chk.sv
module frame_scrambler_chk #(
   parameter int BYTE_W     = 8,
   parameter int LFSR_W     = 15,
   parameter int OUT_STAGES = 1
) (
   input logic              clk,
   input logic              rst_n,
   input logic              in_valid,
   input logic              in_sof,
   input logic [BYTE_W-1:0] in_data,
   input logic              out_valid,
   input logic              out_sof,
   input logic [BYTE_W-1:0] out_data,
   input logic [LFSR_W-1:0] lfsr_state
);
   logic              dv [OUT_STAGES];
   logic              ds [OUT_STAGES];
   logic [BYTE_W-1:0] dd [OUT_STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < OUT_STAGES; i++) begin
            dv[i] <= 1'b0; ds[i] <= 1'b0; dd[i] <= '0;
         end
      end else begin
         dv[0] <= in_valid;
         ds[0] <= in_valid && in_sof;
         dd[0] <= in_data;
         for (int i = 1; i < OUT_STAGES; i++) begin
            dv[i] <= dv[i-1]; ds[i] <= ds[i-1]; dd[i] <= dd[i-1];
         end
      end
   end

   // R1: strobes delayed by the output stages
   a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid == dv[OUT_STAGES-1]) && (out_sof == ds[OUT_STAGES-1]));

   // R1: a marker never appears without a strobe
   a_r1_sof_valid: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> out_valid);

   // R2: the marked byte is a sync byte and leaves unchanged
   a_r2_sync_pass: assert property (@(posedge clk) disable iff (!rst_n)
      out_sof |-> (out_data == dd[OUT_STAGES-1]));

   // R4: the generator restarts from all ones after a marker
   a_r4_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof) |=> (lfsr_state == {LFSR_W{1'b1}}));

   // R5: idle cycles leave the generator untouched
   a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(lfsr_state));

   // R3: the generator never locks up in the all-zero state
   a_r3_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      lfsr_state != '0);

endmodule

bind frame_scrambler frame_scrambler_chk #(
   .BYTE_W    (BYTE_W),
   .LFSR_W    (LFSR_W),
   .OUT_STAGES(OUT_STAGES)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_sof    (in_sof),
   .in_data   (in_data),
   .out_valid (out_valid),
   .out_sof   (out_sof),
   .out_data  (out_data),
   .lfsr_state(lfsr_state)
);

// File: tb/sim_frame_scrambler.sv
`timescale 1ns/1ps
module sim_frame_scrambler;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       in_valid = 1'b0;
   logic       in_sof = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       out_valid;
   logic       out_sof;
   logic [7:0] out_data;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // reference model state
   int m_pos = 59;
   int m_st  = 'h7fff;
   bit [7:0] cap_q [$];
   bit [7:0] last_out;

   always #5 clk = ~clk;

   frame_scrambler u0 (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof),
      .in_data(in_data), .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   function automatic bit [7:0] model_key();
      bit [7:0] k = 0;
      for (int i = 0; i < 8; i++) begin
         int fb = ((m_st >> 14) ^ (m_st >> 13)) & 1;
         k = {k[6:0], fb[0]};
         m_st = ((m_st << 1) | fb) & 'h7fff;
      end
      return k;
   endfunction

   task automatic step(input bit v, input bit s, input bit [7:0] d);
      bit [7:0] exp_d = d;
      string    tag = "R1";
      if (v) begin
         int idx = s ? 0 : m_pos;
         if (s) m_st = 'h7fff;
         if (idx >= 2 && idx < 59) begin
            exp_d = d ^ model_key();
            tag = "R3";
         end else begin
            tag = (idx < 2) ? "R2" : "R7";
         end
         m_pos = (idx < 59) ? idx + 1 : 59;
      end
      in_valid = v; in_sof = s; in_data = d;
      @(posedge clk);
      @(negedge clk);
      chk(out_valid == v, "R1 valid", out_valid, v);
      chk(out_sof == (v && s), "R1 sof", out_sof, v && s);
      if (v) begin
         chk(out_data == exp_d, tag, out_data, exp_d);
         cap_q.push_back(out_data);
      end
      last_out = out_data;
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 1'b0, 8'h00);
   endtask

   initial begin
      #(200000 * 10);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      bit [7:0] frm [59];
      bit [7:0] ref_q [$];
      bit [7:0] scr [59];

      // R8: reset state
      repeat (2) @(negedge clk);
      chk(out_valid == 0 && out_sof == 0 && out_data == 0, "R8 reset",
          {out_valid, out_sof, out_data}, 0);
      rst_n = 1'b1;
      idle(2);

      // R7: bytes before the first marker are untouched
      for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 8'(8'h30 + i));

      // R4: all-zero frame exposes the keystream
      step(1'b1, 1'b1, 8'h47); step(1'b1, 1'b0, 8'h1f);
      step(1'b1, 1'b0, 8'h00); chk(last_out == 8'h00, "R4 key0", last_out, 8'h00);
      step(1'b1, 1'b0, 8'h00); chk(last_out == 8'h02, "R4 key1", last_out, 8'h02);
      for (int i = 4; i < 59; i++) step(1'b1, 1'b0, 8'h00);
      // R7: trailing bytes pass through
      for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 8'(8'hc0 + i));
      idle(1);

      // R5: same frame with and without gaps
      for (int i = 0; i < 59; i++) frm[i] = 8'($urandom);
      cap_q.delete();
      for (int i = 0; i < 59; i++) step(1'b1, i == 0, frm[i]);
      ref_q = cap_q;
      cap_q.delete();
      for (int i = 0; i < 59; i++) begin
         if (i % 5 == 3) idle(1 + i % 3);
         step(1'b1, i == 0, frm[i]);
      end
      for (int i = 0; i < 59; i++)
         chk(cap_q[i] == ref_q[i], "R5 gap", cap_q[i], ref_q[i]);

      // R9: scrambling twice gives back the frame
      for (int i = 0; i < 59; i++) scr[i] = ref_q[i];
      cap_q.delete();
      for (int i = 0; i < 59; i++) step(1'b1, i == 0, scr[i]);
      for (int i = 0; i < 59; i++)
         chk(cap_q[i] == frm[i], "R9 inverse", cap_q[i], frm[i]);

      // R6: early marker restarts the frame
      for (int i = 0; i < 20; i++) step(1'b1, i == 0, 8'(8'h11 * i));
      step(1'b1, 1'b1, 8'hb8); step(1'b1, 1'b0, 8'h55);
      step(1'b1, 1'b0, 8'h5a); chk(last_out == 8'h5a, "R6 restart0", last_out, 8'h5a);
      step(1'b1, 1'b0, 8'h5a); chk(last_out == 8'h58, "R6 restart1", last_out, 8'h58);
      for (int i = 4; i < 62; i++) step(1'b1, 1'b0, 8'(i * 7));
      idle(3);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule